// File: doc/BRIEF.md
# Owner-Side Writeback Buffer

When a caching node evicts a block that it holds dirty or owned, the block goes into this buffer. It stays there until the home node acknowledges the writeback. Until then, the node is still the data source for that block. Any forwarded request from home whose address matches a pending entry is answered from the buffer with the held data. A forwarded request that matches no entry is handed on to the cache array.

Home returns one of two acknowledgement kinds. An accepted acknowledgement means memory took the data. An ignored acknowledgement means home discarded the writeback because a newer owner now holds the block. Both kinds free the matching entry, and the retirement pulse reports which kind it was. The buffer also applies backpressure to the eviction path. It refuses a new eviction while every entry is occupied, and while the same address is still pending.

Top module: `owner_wb_buffer`

## Requirements
- R1: After reset all entries are empty: `full` is 0, `evictReady` is 1, and `rspValid`, `passValid` and `retireValid` are 0.
- R2: An eviction with `evictValid` high while `evictReady` is high is stored in the lowest-numbered free entry at that clock edge, together with its address and data.
- R3: `full` is 1 exactly when all ENTRIES entries are valid. While `full` is 1, `evictReady` is 0, and an eviction offered in that cycle is not stored: a later forwarded request to its address misses.
- R4: While an entry with address A is pending, `evictReady` is 0 for an eviction to A. Such an eviction is not stored.
- R5: A forwarded request (`fwdValid`) whose address matches a valid entry gives, on the next cycle, `rspValid`=1, `rspAddr` equal to the request address, `rspData` equal to the held data, and `passValid`=0.
- R6: A forwarded request that matches no valid entry gives, on the next cycle, `passValid`=1, `passAddr` equal to the request address, and `rspValid`=0. With `fwdValid` low, both are 0 on the next cycle.
- R7: An acknowledgement with `ackKind`=0 (accepted) that matches a valid entry frees that entry. On the next cycle it gives `retireValid`=1, `retireToMem`=1 and `retireAddr` equal to the acknowledged address.
- R8: An acknowledgement with `ackKind`=1 (ignored, stale owner) that matches a valid entry frees that entry. On the next cycle it gives `retireValid`=1 and `retireToMem`=0.
- R9: An acknowledgement whose address matches no valid entry changes no entry and gives `retireValid`=0 on the next cycle.
- R10: Every lookup and the ready decision in a cycle use the entries as they were before that cycle's edge. A forwarded request arriving together with the acknowledgement for the same address still hits. An eviction to an address being acknowledged in that same cycle is still refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evictValid | input | 1 | Eviction push offered |
| evictAddr | input | ADDR_W | Address of the evicted block |
| evictData | input | DATA_W | Data of the evicted block |
| evictReady | output | 1 | Eviction is accepted this cycle |
| full | output | 1 | All entries occupied |
| fwdValid | input | 1 | Forwarded request from home |
| fwdAddr | input | ADDR_W | Forwarded request address |
| rspValid | output | 1 | Data response from the buffer (hit) |
| rspAddr | output | ADDR_W | Address of the data response |
| rspData | output | DATA_W | Held block data |
| passValid | output | 1 | Request passed on to the cache (miss) |
| passAddr | output | ADDR_W | Address of the passed request |
| ackValid | input | 1 | Writeback acknowledgement from home |
| ackAddr | input | ADDR_W | Acknowledged address |
| ackKind | input | 1 | 0 = accepted, 1 = ignored (stale owner) |
| retireValid | output | 1 | An entry was released |
| retireToMem | output | 1 | The released data reached memory |
| retireAddr | output | ADDR_W | Address of the released entry |

## Verification
Some properties are checked by assertions on every cycle. `full` always blocks `evictReady`. Each forwarded request produces exactly one of a data response or a pass-through on the next cycle, and the pass-through carries the request address. A retirement appears only after an acknowledgement, and its memory flag matches the acknowledgement kind. Other behaviour depends on the contents of the entries, and only the bench's reference model shows it. That covers lowest-free allocation, the data returned on a hit, entries surviving until their own acknowledgement, silent discard of unmatched acknowledgements, and the same-cycle ordering of acknowledgement against lookup and eviction.

// File: rtl/owb_pkg.sv
package owb_pkg;
  localparam int IDX_FIELD_W = 8;

  typedef struct packed {
    logic                   allocEn;
    logic [IDX_FIELD_W-1:0] allocIdx;
    logic                   freeEn;
    logic [IDX_FIELD_W-1:0] freeIdx;
    logic                   rspLoad;
  } owbStrobe_t;
endpackage

// File: rtl/owb_data.sv
module owb_data
  import owb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  owbStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  evictAddr,
  input  logic [DATA_W-1:0]  evictData,
  input  logic [ADDR_W-1:0]  fwdAddr,
  input  logic [ADDR_W-1:0]  ackAddr,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] fwdMatch,
  output logic [ENTRIES-1:0] ackMatch,
  output logic [ENTRIES-1:0] evMatch,
  output logic [DATA_W-1:0]  rspData
);
  logic [ADDR_W-1:0] entryAddr [ENTRIES];
  logic [DATA_W-1:0] entryData [ENTRIES];
  logic [DATA_W-1:0] hitData;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    localparam logic [IDX_FIELD_W-1:0] MY_IDX = IDX_FIELD_W'(i);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[i] <= 1'b0;
      end else if (strobe.allocEn && strobe.allocIdx == MY_IDX) begin
        validVec[i] <= 1'b1;
      end else if (strobe.freeEn && strobe.freeIdx == MY_IDX) begin
        validVec[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.allocEn && strobe.allocIdx == MY_IDX) begin
        entryAddr[i] <= evictAddr;
        entryData[i] <= evictData;
      end
    end

    assign fwdMatch[i] = validVec[i] && (entryAddr[i] == fwdAddr);
    assign ackMatch[i] = validVec[i] && (entryAddr[i] == ackAddr);
    assign evMatch[i]  = validVec[i] && (entryAddr[i] == evictAddr);
  end

  // Addresses are unique among valid entries, so the match is one-hot and an OR-mux is enough.
  always_comb begin
    hitData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fwdMatch[i]) hitData = hitData | entryData[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspData <= '0;
    else if (strobe.rspLoad) rspData <= hitData;
  end
endmodule

// File: rtl/owb_ctrl.sv
module owb_ctrl
  import owb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evictValid,
  input  logic               fwdValid,
  input  logic [ADDR_W-1:0]  fwdAddr,
  input  logic               ackValid,
  input  logic [ADDR_W-1:0]  ackAddr,
  input  logic               ackKind,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fwdMatch,
  input  logic [ENTRIES-1:0] ackMatch,
  input  logic [ENTRIES-1:0] evMatch,
  output owbStrobe_t         strobe,
  output logic               evictReady,
  output logic               full,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic               passValid,
  output logic [ADDR_W-1:0]  passAddr,
  output logic               retireValid,
  output logic               retireToMem,
  output logic [ADDR_W-1:0]  retireAddr
);
  logic [IDX_FIELD_W-1:0] freeSlot;
  logic [IDX_FIELD_W-1:0] ackSlot;
  logic                   slotFound;
  logic                   ackFound;
  logic                   fwdHit;
  logic [ADDR_W-1:0]      fwdAddrQ;

  always_comb begin
    freeSlot  = '0;
    slotFound = 1'b0;
    ackSlot   = '0;
    ackFound  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!validVec[i] && !slotFound) begin
        freeSlot  = IDX_FIELD_W'(i);
        slotFound = 1'b1;
      end
      if (ackMatch[i] && !ackFound) begin
        ackSlot  = IDX_FIELD_W'(i);
        ackFound = 1'b1;
      end
    end
  end

  assign full       = &validVec;
  assign fwdHit     = |fwdMatch;
  assign evictReady = !full && !(|evMatch);

  always_comb begin
    strobe          = '0;
    strobe.allocEn  = evictValid && evictReady && slotFound;
    strobe.allocIdx = freeSlot;
    strobe.freeEn   = ackValid && ackFound;
    strobe.freeIdx  = ackSlot;
    strobe.rspLoad  = fwdValid && fwdHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      passValid   <= 1'b0;
      retireValid <= 1'b0;
      retireToMem <= 1'b0;
      retireAddr  <= '0;
      fwdAddrQ    <= '0;
    end else begin
      rspValid    <= fwdValid && fwdHit;
      passValid   <= fwdValid && !fwdHit;
      retireValid <= strobe.freeEn;
      if (fwdValid) fwdAddrQ <= fwdAddr;
      if (strobe.freeEn) begin
        retireToMem <= !ackKind;
        retireAddr  <= ackAddr;
      end
    end
  end

  assign rspAddr  = fwdAddrQ;
  assign passAddr = fwdAddrQ;
endmodule

// File: rtl/owner_wb_buffer.sv
module owner_wb_buffer
  import owb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [DATA_W-1:0] evictData,
  output logic              evictReady,
  output logic              full,
  input  logic              fwdValid,
  input  logic [ADDR_W-1:0] fwdAddr,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [DATA_W-1:0] rspData,
  output logic              passValid,
  output logic [ADDR_W-1:0] passAddr,
  input  logic              ackValid,
  input  logic [ADDR_W-1:0] ackAddr,
  input  logic              ackKind,
  output logic              retireValid,
  output logic              retireToMem,
  output logic [ADDR_W-1:0] retireAddr
);
  owbStrobe_t         strobe;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] fwdMatch;
  logic [ENTRIES-1:0] ackMatch;
  logic [ENTRIES-1:0] evMatch;

  owb_ctrl #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .evictValid(evictValid),
    .fwdValid(fwdValid), .fwdAddr(fwdAddr),
    .ackValid(ackValid), .ackAddr(ackAddr), .ackKind(ackKind),
    .validVec(validVec), .fwdMatch(fwdMatch), .ackMatch(ackMatch), .evMatch(evMatch),
    .strobe(strobe), .evictReady(evictReady), .full(full),
    .rspValid(rspValid), .rspAddr(rspAddr),
    .passValid(passValid), .passAddr(passAddr),
    .retireValid(retireValid), .retireToMem(retireToMem), .retireAddr(retireAddr)
  );

  owb_data #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .evictAddr(evictAddr), .evictData(evictData),
    .fwdAddr(fwdAddr), .ackAddr(ackAddr),
    .validVec(validVec), .fwdMatch(fwdMatch), .ackMatch(ackMatch), .evMatch(evMatch),
    .rspData(rspData)
  );
endmodule

// File: rtl/owb_checker.sv
module owb_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              evictReady,
  input logic              full,
  input logic              fwdValid,
  input logic [ADDR_W-1:0] fwdAddr,
  input logic              rspValid,
  input logic              passValid,
  input logic [ADDR_W-1:0] passAddr,
  input logic              ackValid,
  input logic              ackKind,
  input logic              retireValid,
  input logic              retireToMem
);
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !evictReady);

  p_one_answer_r5: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |=> (rspValid != passValid));

  p_no_answer_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fwdValid |=> (!rspValid && !passValid));

  p_pass_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |=> (!passValid || passAddr == $past(fwdAddr)));

  p_retire_needs_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ackValid |=> !retireValid);

  p_retire_kind_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> (!retireValid || retireToMem == !$past(ackKind)));
endmodule

bind owner_wb_buffer owb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .evictReady(evictReady), .full(full),
  .fwdValid(fwdValid), .fwdAddr(fwdAddr), .rspValid(rspValid),
  .passValid(passValid), .passAddr(passAddr), .ackValid(ackValid),
  .ackKind(ackKind), .retireValid(retireValid), .retireToMem(retireToMem)
);

// File: tb/tb_owner_wb_buffer.sv
module tb_owner_wb_buffer;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evictValid = 1'b0, fwdValid = 1'b0, ackValid = 1'b0, ackKind = 1'b0;
  logic [AW-1:0] evictAddr = '0, fwdAddr = '0, ackAddr = '0;
  logic [DW-1:0] evictData = '0;
  logic evictReady, full, rspValid, passValid, retireValid, retireToMem;
  logic [AW-1:0] rspAddr, passAddr, retireAddr;
  logic [DW-1:0] rspData;

  int checks = 0, fails = 0;
  bit done = 0;

  logic          mValid [N];
  logic [AW-1:0] mAddr  [N];
  logic [DW-1:0] mData  [N];

  always #5 clk = ~clk;

  owner_wb_buffer #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

  function automatic int findIdx(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mValid[i] && mAddr[i] == a) return i;
    return -1;
  endfunction

  function automatic int lowestFree();
    for (int i = 0; i < N; i++) if (!mValid[i]) return i;
    return -1;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one cycle starting at a negedge, checks combinational outputs,
  // then after the edge checks registered outputs at the next negedge.
  task automatic step(input bit ev, input logic [AW-1:0] eA, input logic [DW-1:0] eD,
                      input bit fw, input logic [AW-1:0] fA,
                      input bit ak, input logic [AW-1:0] aA, input bit aK);
    int fIdx, aIdx, slot;
    bit expFull, expReady;
    logic [DW-1:0] expData;
    evictValid = ev; evictAddr = eA; evictData = eD;
    fwdValid = fw; fwdAddr = fA;
    ackValid = ak; ackAddr = aA; ackKind = aK;
    #1;
    expFull  = (lowestFree() < 0);
    expReady = !expFull && (findIdx(eA) < 0);
    check("R3 full", 64'(full), 64'(expFull));
    check("R4/R3 evictReady", 64'(evictReady), 64'(expReady));
    fIdx = findIdx(fA);
    aIdx = findIdx(aA);
    slot = lowestFree();
    expData = (fIdx >= 0) ? mData[fIdx] : '0;
    if (ak && aIdx >= 0) mValid[aIdx] = 1'b0;
    if (ev && expReady) begin
      mValid[slot] = 1'b1; mAddr[slot] = eA; mData[slot] = eD;
    end
    @(negedge clk);
    check("R5 rspValid", 64'(rspValid), 64'(fw && fIdx >= 0));
    check("R6 passValid", 64'(passValid), 64'(fw && fIdx < 0));
    if (fw && fIdx >= 0) begin
      check("R5 rspData", 64'(rspData), 64'(expData));
      check("R5 rspAddr", 64'(rspAddr), 64'(fA));
    end
    if (fw && fIdx < 0) check("R6 passAddr", 64'(passAddr), 64'(fA));
    check("R9 retireValid", 64'(retireValid), 64'(ak && aIdx >= 0));
    if (ak && aIdx >= 0) begin
      check("R7/R8 retireToMem", 64'(retireToMem), 64'(!aK));
      check("R7 retireAddr", 64'(retireAddr), 64'(aA));
    end
  endtask

  task automatic idle();
    step(0, '0, '0, 0, '0, 0, '0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mAddr[i] = '0; mData[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 full", 64'(full), 64'd0);
    check("R1 evictReady", 64'(evictReady), 64'd1);
    check("R1 rspValid", 64'(rspValid), 64'd0);
    check("R1 passValid", 64'(passValid), 64'd0);
    check("R1 retireValid", 64'(retireValid), 64'd0);
    @(negedge clk);
    // R2 fill all entries, R3 full
    for (int i = 0; i < N; i++) step(1, AW'(16'h100 + i), DW'(32'hA000 + i), 0, '0, 0, '0, 0);
    idle();
    // R3: eviction while full is dropped, its address then misses
    step(1, 16'h777, 32'hDEAD, 0, '0, 0, '0, 0);
    step(0, '0, '0, 1, 16'h777, 0, '0, 0);
    // R5 hit on each entry
    for (int i = 0; i < N; i++) step(0, '0, '0, 1, AW'(16'h100 + i), 0, '0, 0);
    // R7 accepted ack frees entry 1; R10 forward to the same address in the same cycle still hits
    step(0, '0, '0, 1, 16'h101, 1, 16'h101, 0);
    step(0, '0, '0, 1, 16'h101, 0, '0, 0);
    // R4 duplicate eviction to 0x102 refused
    step(1, 16'h102, 32'hBEEF, 0, '0, 0, '0, 0);
    step(0, '0, '0, 1, 16'h102, 0, '0, 0);
    // R8 ignored ack; R10 eviction of acked address same cycle refused
    step(1, 16'h103, 32'h5555, 0, '0, 1, 16'h103, 1);
    step(0, '0, '0, 1, 16'h103, 0, '0, 0);
    // R9 unmatched ack
    step(0, '0, '0, 0, '0, 1, 16'h999, 0);
    // R2 lowest free slot reused, then readback
    step(1, 16'h200, 32'h1234, 0, '0, 0, '0, 0);
    step(0, '0, '0, 1, 16'h200, 0, '0, 0);
    // Random mix over a small address pool
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 3) != 0, AW'($urandom % 8), DW'($urandom),
           ($urandom % 2) == 1, AW'($urandom % 8),
           ($urandom % 3) == 0, AW'($urandom % 8), ($urandom % 2) == 1);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule